// File: doc/BRIEF.md
# Bit-Slice Ripple-Carry ALU

This block is a purely combinational integer ALU made from a row of identical one-bit cells. Each cell holds a full adder and a two-gate logic unit, and it can optionally complement either of its operand bits. The cells are joined by a ripple carry. A four-bit control word chooses the operation: bitwise AND, OR or NOR, addition, subtraction, or a signed set-on-less-than.

The control word is `{invert_a, negate_b, op_field[1:0]}`. `negate_b` complements B in every cell and also sets the carry into the lowest cell, so subtraction reuses the adder. NOR is the AND path with both operands complemented. Set-on-less-than subtracts B from A, corrects the sign of the difference with the overflow bit, and places the outcome in bit 0.

The block sits inside a datapath between operand selection and write-back. The zero flag serves equality tests after a subtraction.

Top module: `ripple_alu`

## Requirements
- R1: Control 0000 (op_field 00, the AND path) gives `result = src_a & src_b`.
- R2: Control 0001 (op_field 01, the OR path) gives `result = src_a | src_b`.
- R3: Control 0010 (op_field 10, the sum path) gives `result = src_a + src_b` modulo 2^WIDTH. `carry_out` equals bit WIDTH of the unsigned sum.
- R4: Control 0110 gives `result = src_a - src_b` modulo 2^WIDTH. `carry_out` is 1 exactly when `src_a >= src_b` taken as unsigned numbers.
- R5: Control 1100 gives `result = ~(src_a | src_b)`.
- R6: Control 0111 (op_field 11) gives result bit 0 = 1 when `src_a < src_b` as two's-complement signed numbers, including operand pairs whose difference overflows. All other result bits are 0.
- R7: `zero` is 1 exactly when every bit of `result` is 0, for every control value.
- R8: When op_field is 10 or 11, `overflow` is 1 exactly when the two's-complement sum of the effective operands plus the LSB carry overflows. When op_field is 00 or 01, `overflow` and `carry_out` are both 0.
- R9: Control bit 3 complements A and control bit 2 complements B (and sets the LSB carry to 1), whatever the op_field. For example, 1010 gives `~src_a + src_b` and 0100 gives `src_a & ~src_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | WIDTH | First operand |
| src_b | input | WIDTH | Second operand |
| alu_ctl | input | 4 | {invert_a, negate_b, op_field[1:0]} |
| result | output | WIDTH | Operation result |
| zero | output | 1 | All result bits are 0 |
| carry_out | output | 1 | Carry out of the top cell (arithmetic op_fields only) |
| overflow | output | 1 | Signed overflow (arithmetic op_fields only) |

## Verification
The hardest case to reach is a set-on-less-than whose internal subtraction overflows. In that case the raw sign bit gives the wrong answer and only the overflow correction saves it. Random operands rarely produce such a pair, so the stimulus applies the most negative and the most positive values directly against small values and against -1. The table and the random sweep also cover control words outside the six named operations, which exercises the independent inversion controls.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int CTL_W = 4;

    typedef enum logic [1:0] {
        OPF_AND  = 2'b00,
        OPF_OR   = 2'b01,
        OPF_SUM  = 2'b10,
        OPF_LESS = 2'b11
    } opfield_e;
endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
    import alu_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    output logic             inv_a,
    output logic             neg_b,
    output opfield_e         op_sel,
    output logic             arith
);
    always_comb begin
        inv_a  = ctl[3];
        neg_b  = ctl[2];
        op_sel = opfield_e'(ctl[1:0]);
        arith  = (op_sel == OPF_SUM) || (op_sel == OPF_LESS);
    end
endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
    import alu_pkg::*;
(
    input  logic     a,
    input  logic     b,
    input  logic     inv_a,
    input  logic     inv_b,
    input  logic     cin,
    input  logic     less_in,
    input  opfield_e op_sel,
    output logic     res,
    output logic     cout
);
    logic a_eff;
    logic b_eff;
    logic sum;

    always_comb begin
        a_eff = a ^ inv_a;
        b_eff = b ^ inv_b;
        sum   = a_eff ^ b_eff ^ cin;
        cout  = (b_eff & cin) | (a_eff & cin) | (a_eff & b_eff);
        unique case (op_sel)
            OPF_AND:  res = a_eff & b_eff;
            OPF_OR:   res = a_eff | b_eff;
            OPF_SUM:  res = sum;
            default:  res = less_in;
        endcase
    end
endmodule

// File: rtl/alu_sign_unit.sv
module alu_sign_unit (
    input  logic a_msb,
    input  logic b_msb,
    input  logic inv_a,
    input  logic inv_b,
    input  logic carry_into_msb,
    input  logic carry_from_msb,
    output logic ovf_raw,
    output logic less_bit
);
    logic msb_sum;

    always_comb begin
        msb_sum  = (a_msb ^ inv_a) ^ (b_msb ^ inv_b) ^ carry_into_msb;
        ovf_raw  = carry_into_msb ^ carry_from_msb;
        less_bit = msb_sum ^ ovf_raw;
    end
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic [CTL_W-1:0] alu_ctl,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             carry_out,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    logic       inv_a;
    logic       neg_b;
    logic       arith;
    opfield_e   op_sel;
    logic [WIDTH:0] carry;
    logic       ovf_raw;
    logic       less_bit;

    alu_ctl_decode u_dec (
        .ctl    (alu_ctl),
        .inv_a  (inv_a),
        .neg_b  (neg_b),
        .op_sel (op_sel),
        .arith  (arith)
    );

    assign carry[0] = neg_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic less_in;
        if (i == 0) begin : g_lsb
            assign less_in = less_bit;
        end else begin : g_upper
            assign less_in = 1'b0;
        end
        alu_bit_cell u_cell (
            .a       (src_a[i]),
            .b       (src_b[i]),
            .inv_a   (inv_a),
            .inv_b   (neg_b),
            .cin     (carry[i]),
            .less_in (less_in),
            .op_sel  (op_sel),
            .res     (result[i]),
            .cout    (carry[i+1])
        );
    end

    alu_sign_unit u_sign (
        .a_msb          (src_a[MSB]),
        .b_msb          (src_b[MSB]),
        .inv_a          (inv_a),
        .inv_b          (neg_b),
        .carry_into_msb (carry[MSB]),
        .carry_from_msb (carry[WIDTH]),
        .ovf_raw        (ovf_raw),
        .less_bit       (less_bit)
    );

    always_comb begin
        zero      = ~|result;
        carry_out = arith & carry[WIDTH];
        overflow  = arith & ovf_raw;
    end

    always_comb begin
        if (alu_ctl == 4'b0000)
            assert_and_path_R1: assert (result == (src_a & src_b));
        if (alu_ctl == 4'b0010)
            assert_add_sum_R3: assert ({carry_out, result} ==
                                       ({1'b0, src_a} + {1'b0, src_b}));
        if (alu_ctl == 4'b0110)
            assert_sub_diff_R4: assert (result == (src_a - src_b));
        if (alu_ctl == 4'b1100)
            assert_nor_path_R5: assert (result == ~(src_a | src_b));
        if (alu_ctl[1:0] == 2'b11)
            assert_less_upper_clear_R6: assert (result[MSB:1] == '0);
        if (alu_ctl[1] == 1'b0)
            assert_logic_no_flags_R8: assert (!carry_out && !overflow);
    end
endmodule

// File: tb/ripple_alu_test.sv
module ripple_alu_test;
    localparam int W = 32;
    localparam int NVEC = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic [3:0]   alu_ctl = 4'b0000;
    logic [W-1:0] result;
    logic zero, carry_out, overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ripple_alu #(.WIDTH(W)) uut (
        .src_a(src_a), .src_b(src_b), .alu_ctl(alu_ctl),
        .result(result), .zero(zero), .carry_out(carry_out), .overflow(overflow)
    );

    // {ctl, a, b}
    localparam logic [67:0] VEC [NVEC] = '{
        {4'b0000, 32'hF0F0_F0F0, 32'hFF00_FF00},
        {4'b0001, 32'h1234_0000, 32'h0000_5678},
        {4'b0010, 32'h0000_0001, 32'h0000_0002},
        {4'b0010, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {4'b0110, 32'h0000_0010, 32'h0000_0020},
        {4'b0110, 32'h8000_0000, 32'h7FFF_FFFF},
        {4'b1100, 32'hAAAA_5555, 32'h0F0F_0F0F},
        {4'b1100, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'b0111, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'b0111, 32'h0000_0000, 32'hFFFF_FFFF},
        {4'b0111, 32'h8000_0000, 32'h7FFF_FFFF},
        {4'b0111, 32'h7FFF_FFFF, 32'h8000_0000},
        {4'b1010, 32'h0000_0005, 32'h0000_0009},
        {4'b0100, 32'hDEAD_BEEF, 32'h0000_FFFF},
        {4'b0101, 32'h0000_0000, 32'hFFFF_0000},
        {4'b1110, 32'h0000_0003, 32'h0000_0004}
    };

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b1100: return "R5";
            4'b0111: return "R6";
            default: return "R9";
        endcase
    endfunction

    // reference model: returns {result, zero, carry, ovf}
    function automatic logic [W+2:0] model(input logic [3:0] c,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] aa, bb, r;
        logic [W:0]   s;
        logic         v, cy;
        aa = c[3] ? ~a : a;
        bb = c[2] ? ~b : b;
        s  = {1'b0, aa} + {1'b0, bb} + {{W{1'b0}}, c[2]};
        v  = (aa[W-1] == bb[W-1]) && (s[W-1] != aa[W-1]);
        cy = s[W];
        case (c[1:0])
            2'b00: begin r = aa & bb; cy = 1'b0; v = 1'b0; end
            2'b01: begin r = aa | bb; cy = 1'b0; v = 1'b0; end
            2'b10: r = s[W-1:0];
            default: r = {{(W-1){1'b0}}, s[W-1] ^ v};
        endcase
        return {r, (r == '0), cy, v};
    endfunction

    task automatic apply(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        alu_ctl = c; src_a = a; src_b = b;
        @(posedge clk);
        #1;
    endtask

    task automatic compare(input string tag, input logic [W+2:0] exp);
        logic [W+2:0] act;
        act = {result, zero, carry_out, overflow};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s ctl=%b a=%h b=%h actual res=%h z=%b c=%b v=%b expected res=%h z=%b c=%b v=%b",
                     tag, alu_ctl, src_a, src_b, act[W+2:3], act[2], act[1], act[0],
                     exp[W+2:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic check_model(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        apply(c, a, b);
        compare(tag_of(c), model(c, a, b));
    endtask

    task automatic check_hand(input string tag, input logic [3:0] c,
                              input logic [W-1:0] a, input logic [W-1:0] b,
                              input logic [W-1:0] er, input logic ez, input logic ec, input logic ev);
        apply(c, a, b);
        compare(tag, {er, ez, ec, ev});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] ops [6];
        ops = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b1100, 4'b0111};

        // initial state: all-zero inputs, AND path (R7)
        @(posedge clk); #1;
        compare("R7", {32'h0, 1'b1, 1'b0, 1'b0});

        for (int i = 0; i < NVEC; i++)
            check_model(VEC[i][67:64], VEC[i][63:32], VEC[i][31:0]);

        for (int k = 0; k < 6; k++)
            for (int n = 0; n < 200; n++)
                check_model(ops[k], $urandom, $urandom);
        for (int n = 0; n < 100; n++)
            check_model(4'($urandom), $urandom, $urandom);

        // directed corner cases with hand-derived expectations
        check_hand("R3", 4'b0010, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b1, 1'b1, 1'b0);
        check_hand("R8", 4'b0010, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1'b0, 1'b0, 1'b1);
        check_hand("R7", 4'b0110, 32'h5, 32'h5, 32'h0, 1'b1, 1'b1, 1'b0);
        check_hand("R4", 4'b0110, 32'h0, 32'h1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        check_hand("R8", 4'b0110, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1);
        check_hand("R6", 4'b0111, 32'h8000_0000, 32'h1, 32'h1, 1'b0, 1'b1, 1'b1);
        check_hand("R6", 4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b1);
        check_hand("R6", 4'b0111, 32'h3, 32'h3, 32'h0, 1'b1, 1'b1, 1'b0);
        check_hand("R5", 4'b1100, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        check_hand("R1", 4'b0000, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0, 1'b1, 1'b0, 1'b0);
        check_hand("R2", 4'b0001, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        check_hand("R9", 4'b1010, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        check_hand("R9", 4'b0100, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule